// File: doc/BRIEF.md
# Calendar Time Counter with Update Window

This block holds a time of day and a position in the week and month as five byte-wide counters: seconds, minutes, hours, day of week and day of month. A 1 Hz tick starts each advance. A slower reference enable, nominally 32.768 kHz, sets when the advance happens and how long it lasts. A status flag shows that an update window is open. The counters change a fixed number of reference ticks after the flag rises. The flag then stays high for a fixed number of further ticks. When the window closes, a one-clock strobe marks the finished update.

The counters hold either packed decimal digits or plain binary, chosen at run time by a control bit. Hours run either 0 to 23 or 1 to 12 with a PM flag, again chosen by a control bit. Software reads and writes every field through a byte-wide register port. While a control bit named `hold` is set, no window opens and any open window is abandoned, so software can load a new time without a race.

Top module: `caltime_core`

## Requirements
- R1: After reset, seconds, minutes and hours read 0x00, day of week and day of month read 0x01, control reads 0x02, and `uip` and `upd_done` are low.
- R2: Register offsets are: seconds 0x0, minutes 0x2, hours 0x4, day of week 0x6, day of month 0x7, status 0xA (bit 7 = window open), control 0xB (bit 7 hold, bit 2 binary, bit 1 24-hour), validity 0xD (always 0x80). Writes to 0xA and 0xD are ignored, undefined offsets read 0x00, and a write to a time or control register shows on the next clock.
- R3: With hold clear, a `sec_tick` pulse raises `uip` on the next clock, and the time registers change at the clock that samples the LEAD_TICKS-th (8) `ref_tick` after that.
- R4: After the change, `uip` stays high for UPD_TICKS (65) more `ref_tick` pulses and falls at the clock that samples the last of them. `upd_done` is high for exactly that one clock.
- R5: Seconds count 0 to 59 and wrap to 0. Their wrap advances minutes, which count 0 to 59 and wrap to 0 with a carry into hours.
- R6: With control bit 2 clear, every time byte is two decimal digits, tens in bits 7:4 and units in bits 3:0. With it set, the byte is the plain binary value.
- R7: With control bit 1 set, hours count 0 to 23, and the step from 23 to 0 is a day carry.
- R8: With control bit 1 clear, hours bits 6:0 count 1 to 12 and bit 7 is PM. The step from 11 goes to 12 and toggles PM, and the step from 12 goes to 1. The step from 11 PM to 12 AM is a day carry.
- R9: On a day carry, day of week steps 1 to 7 and wraps to 1, and day of month steps 1 to 31 and wraps to 1.
- R10: While hold is set, `sec_tick` opens no window, the time does not change and `upd_done` stays low. Setting hold inside an open window drops `uip` within two clocks of the write, with no time change and no `upd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-clock pulse once per second |
| ref_tick | input | 1 | One-clock enable at the reference rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register offset for read and write |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| uip | output | 1 | Update window open |
| upd_done | output | 1 | One-clock strobe when an update window completes |

## Verification
A sequencer counting wrong shows up as a wrong number of reference ticks between the rise of `uip` and the change of the seconds byte, or between that change and the fall of `uip`. Every window exposes it. A field decoded in the wrong format, or a carry taken at the wrong value, appears in the registers read back right after the advance that crosses that value. The bench therefore starts from every hour of the day in all four format and mode combinations. A hold that fails to freeze or to abort shows as a raised `uip` or a moved seconds byte within a couple of clocks.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

   localparam int unsigned BYTE_W = 8;

   localparam int unsigned OFS_SEC   = 0;
   localparam int unsigned OFS_MIN   = 2;
   localparam int unsigned OFS_HOUR  = 4;
   localparam int unsigned OFS_WDAY  = 6;
   localparam int unsigned OFS_MDAY  = 7;
   localparam int unsigned OFS_STAT  = 10;
   localparam int unsigned OFS_CTRL  = 11;
   localparam int unsigned OFS_VALID = 13;

   localparam logic [BYTE_W-1:0] VALID_WORD = 8'h80;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_LEAD = 2'd1,
      SEQ_UPD  = 2'd2
   } seq_state_t;

   // decode a stored byte into its numeric value
   function automatic logic [BYTE_W-1:0] to_num(input logic [BYTE_W-1:0] v, input logic dec);
      logic [BYTE_W-1:0] tens;
      tens = {4'd0, v[7:4]};
      return dec ? (tens * 8'd10 + {4'd0, v[3:0]}) : v;
   endfunction

   // encode a numeric value into the stored byte format
   function automatic logic [BYTE_W-1:0] from_num(input logic [BYTE_W-1:0] v, input logic dec);
      logic [BYTE_W-1:0] t;
      logic [BYTE_W-1:0] u;
      t = v / 8'd10;
      u = v % 8'd10;
      return dec ? {t[3:0], u[3:0]} : v;
   endfunction

endpackage

// File: rtl/caltime_seq.sv
module caltime_seq
   import caltime_pkg::*;
#(
   parameter int unsigned LEAD_TICKS = 8,
   parameter int unsigned UPD_TICKS  = 65
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_tick,
   input  logic ref_tick,
   input  logic hold,
   output logic uip,
   output logic adv,
   output logic done
);

   localparam int unsigned MAX_T = (LEAD_TICKS > UPD_TICKS) ? LEAD_TICKS : UPD_TICKS;
   localparam int unsigned CNT_W = $clog2(MAX_T + 1);
   localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_TICKS - 1);
   localparam logic [CNT_W-1:0] UPD_LAST  = CNT_W'(UPD_TICKS - 1);

   initial begin
      assert (LEAD_TICKS >= 1) else $error("caltime_seq: LEAD_TICKS must be at least 1");
      assert (UPD_TICKS >= 1) else $error("caltime_seq: UPD_TICKS must be at least 1");
   end

   seq_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   logic             lead_end;
   logic             upd_end;

   always_comb begin
      lead_end = (state_q == SEQ_LEAD) && ref_tick && (cnt_q == LEAD_LAST);
      upd_end  = (state_q == SEQ_UPD)  && ref_tick && (cnt_q == UPD_LAST);
      adv      = lead_end && !hold;
      uip      = (state_q != SEQ_IDLE);
      done     = done_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= upd_end && !hold;
         if (hold) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
         end else begin
            unique case (state_q)
               SEQ_IDLE: begin
                  cnt_q <= '0;
                  if (sec_tick) state_q <= SEQ_LEAD;
               end
               SEQ_LEAD: begin
                  if (ref_tick) begin
                     if (lead_end) begin
                        state_q <= SEQ_UPD;
                        cnt_q   <= '0;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               SEQ_UPD: begin
                  if (ref_tick) begin
                     if (upd_end) begin
                        state_q <= SEQ_IDLE;
                        cnt_q   <= '0;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               default: begin
                  state_q <= SEQ_IDLE;
                  cnt_q   <= '0;
               end
            endcase
         end
      end
   end

   // R3: an accepted second tick opens the window on the next clock
   assert_tick_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !hold && !uip) |=> uip);

   // R4: the completion strobe coincides with the window closing
   assert_done_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!uip && $past(uip)));

   // R10: hold always closes the window
   assert_hold_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (!uip && !done));

endmodule

// File: rtl/caltime_field.sv
module caltime_field
   import caltime_pkg::*;
#(
   parameter int unsigned LO = 0,
   parameter int unsigned HI = 59
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              dec,
   input  logic              load,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] q,
   output logic              at_top
);

   localparam logic [BYTE_W-1:0] LO_V = BYTE_W'(LO);
   localparam logic [BYTE_W-1:0] HI_V = BYTE_W'(HI);

   initial begin
      assert (HI > LO && HI < 100) else $error("caltime_field: range must satisfy LO < HI < 100");
   end

   logic [BYTE_W-1:0] cur_num;
   logic [BYTE_W-1:0] nxt_num;

   always_comb begin
      cur_num = to_num(q, dec);
      at_top  = (cur_num >= HI_V);
      nxt_num = at_top ? LO_V : (cur_num + 1'b1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= LO_V;
      else if (load) q <= wdata;
      else if (adv)  q <= from_num(nxt_num, dec);
   end

   // R5 / R9: an advance never leaves the counting range
   assert_field_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(adv) && !$past(load) && (dec == $past(dec)))
      |-> ((to_num(q, dec) >= LO_V) && (to_num(q, dec) <= HI_V)));

endmodule

// File: rtl/caltime_hour.sv
module caltime_hour
   import caltime_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              dec,
   input  logic              full_day,
   input  logic              load,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] q,
   output logic              day_carry
);

   logic [BYTE_W-1:0] cur_num;
   logic [BYTE_W-1:0] nxt_num;
   logic              pm_nxt;
   logic [BYTE_W-1:0] nxt_byte;

   always_comb begin
      cur_num   = to_num({1'b0, q[6:0]}, dec);
      nxt_num   = '0;
      pm_nxt    = 1'b0;
      day_carry = 1'b0;
      if (full_day) begin
         day_carry = (cur_num >= 8'd23);
         nxt_num   = day_carry ? 8'd0 : (cur_num + 1'b1);
         nxt_byte  = from_num(nxt_num, dec);
      end else begin
         pm_nxt = q[7];
         if (cur_num == 8'd11) begin
            nxt_num   = 8'd12;
            pm_nxt    = !q[7];
            day_carry = q[7];
         end else if (cur_num >= 8'd12) begin
            nxt_num = 8'd1;
         end else begin
            nxt_num = cur_num + 1'b1;
         end
         nxt_byte = from_num(nxt_num, dec);
         nxt_byte = {pm_nxt, nxt_byte[6:0]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= wdata;
      else if (adv)  q <= nxt_byte;
   end

   // R8: in 12-hour mode the step out of 11 flips the PM flag
   assert_pm_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(adv) && !$past(load) && !full_day && !$past(full_day)
       && (dec == $past(dec)) && ($past(cur_num) == 8'd11))
      |-> (q[7] != $past(q[7])));

   // R7: in 24-hour mode the hour field never shows the PM flag after an advance
   assert_no_flag_24h_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(adv) && !$past(load) && $past(full_day)) |-> !q[7]);

endmodule

// File: rtl/caltime_core.sv
module caltime_core
   import caltime_pkg::*;
#(
   parameter int unsigned LEAD_TICKS = 8,
   parameter int unsigned UPD_TICKS  = 65,
   parameter int unsigned ADDR_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              ref_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rd_data,
   output logic              uip,
   output logic              upd_done
);

   initial begin
      assert (ADDR_W >= 4) else $error("caltime_core: ADDR_W must reach offset 13");
   end

   logic hold_q, bin_q, h24_q;
   logic ld_sec, ld_min, ld_hour, ld_wday, ld_mday, ld_ctrl;
   logic adv_any, adv_min, adv_hour, adv_day;
   logic sec_top, min_top, wday_top, mday_top, day_carry;
   logic dec;
   logic [BYTE_W-1:0] sec_q, min_q, hour_q, wday_q, mday_q;

   always_comb begin
      dec     = !bin_q;
      ld_sec  = wr_en && (addr == ADDR_W'(OFS_SEC));
      ld_min  = wr_en && (addr == ADDR_W'(OFS_MIN));
      ld_hour = wr_en && (addr == ADDR_W'(OFS_HOUR));
      ld_wday = wr_en && (addr == ADDR_W'(OFS_WDAY));
      ld_mday = wr_en && (addr == ADDR_W'(OFS_MDAY));
      ld_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
      adv_min  = adv_any && sec_top;
      adv_hour = adv_min && min_top;
      adv_day  = adv_hour && day_carry;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         bin_q  <= 1'b0;
         h24_q  <= 1'b1;
      end else if (ld_ctrl) begin
         hold_q <= wdata[7];
         bin_q  <= wdata[2];
         h24_q  <= wdata[1];
      end
   end

   caltime_seq #(.LEAD_TICKS(LEAD_TICKS), .UPD_TICKS(UPD_TICKS)) seq_i (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ref_tick(ref_tick),
      .hold(hold_q), .uip(uip), .adv(adv_any), .done(upd_done)
   );

   caltime_field #(.LO(0), .HI(59)) sec_i (
      .clk(clk), .rst_n(rst_n), .adv(adv_any), .dec(dec), .load(ld_sec),
      .wdata(wdata), .q(sec_q), .at_top(sec_top)
   );

   caltime_field #(.LO(0), .HI(59)) min_i (
      .clk(clk), .rst_n(rst_n), .adv(adv_min), .dec(dec), .load(ld_min),
      .wdata(wdata), .q(min_q), .at_top(min_top)
   );

   caltime_hour hour_i (
      .clk(clk), .rst_n(rst_n), .adv(adv_hour), .dec(dec), .full_day(h24_q),
      .load(ld_hour), .wdata(wdata), .q(hour_q), .day_carry(day_carry)
   );

   caltime_field #(.LO(1), .HI(7)) wday_i (
      .clk(clk), .rst_n(rst_n), .adv(adv_day), .dec(dec), .load(ld_wday),
      .wdata(wdata), .q(wday_q), .at_top(wday_top)
   );

   caltime_field #(.LO(1), .HI(31)) mday_i (
      .clk(clk), .rst_n(rst_n), .adv(adv_day), .dec(dec), .load(ld_mday),
      .wdata(wdata), .q(mday_q), .at_top(mday_top)
   );

   always_comb begin
      rd_data = '0;
      unique case (addr)
         ADDR_W'(OFS_SEC):   rd_data = sec_q;
         ADDR_W'(OFS_MIN):   rd_data = min_q;
         ADDR_W'(OFS_HOUR):  rd_data = hour_q;
         ADDR_W'(OFS_WDAY):  rd_data = wday_q;
         ADDR_W'(OFS_MDAY):  rd_data = mday_q;
         ADDR_W'(OFS_STAT):  rd_data = {uip, 7'd0};
         ADDR_W'(OFS_CTRL):  rd_data = {hold_q, 4'd0, bin_q, h24_q, 1'b0};
         ADDR_W'(OFS_VALID): rd_data = VALID_WORD;
         default:            rd_data = '0;
      endcase
   end

   // R10: with hold set and no write, the seconds byte is frozen
   assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hold_q) && !$past(ld_sec)) |-> $stable(sec_q));

   // R3: the seconds byte changes only inside an open window, or by a write
   assert_change_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ld_sec) && !$stable(sec_q)) |-> $past(uip));

   // R9: the day counters move together on a day carry
   assert_days_together_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ld_wday) && !$past(ld_mday) && !$stable(wday_q)) |-> !$stable(mday_q));

   // R2: the validity register is constant
   assert_valid_const_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(OFS_VALID)) |-> (rd_data == VALID_WORD));

   logic unused_top;
   assign unused_top = wday_top ^ mday_top ^ (^wdata[6:3]) ^ wdata[0];

endmodule

// File: tb/caltime_core_tb_top.sv
`timescale 1ns/1ps
module caltime_core_tb_top;

   localparam int LEAD = 8;
   localparam int UPD  = 65;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sec_tick = 1'b0;
   logic       ref_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] addr = 4'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rd_data;
   logic       uip;
   logic       upd_done;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   // model state: hours kept as 0..23
   int ms, mm, mh, mw, md;
   bit m_bin, m_h24;

   always #2.5 clk = ~clk;

   caltime_core #(.LEAD_TICKS(LEAD), .UPD_TICKS(UPD), .ADDR_W(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ref_tick(ref_tick),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rd_data),
      .uip(uip), .upd_done(upd_done)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic int enc(input int v, input bit bin);
      return bin ? v : (((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int hour_byte(input int h, input bit bin, input bit h24);
      int h12;
      if (h24) return enc(h, bin);
      h12 = (h % 12 == 0) ? 12 : (h % 12);
      return ((h >= 12) ? 8'h80 : 0) | enc(h12, bin);
   endfunction

   function automatic int ctrl_byte(input bit hold, input bit bin, input bit h24);
      return (hold ? 8'h80 : 0) | (bin ? 4 : 0) | (h24 ? 2 : 0);
   endfunction

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; addr = 4'(a); wdata = 8'(d);
      @(negedge clk);
      wr_en = 1'b0; addr = 4'd0; wdata = 8'd0;
   endtask

   task automatic rd(input int a, output int v);
      addr = 4'(a);
      #1;
      v = int'(rd_data);
      addr = 4'd0;
      #1;
   endtask

   task automatic load_model();
      wr(11, ctrl_byte(0, m_bin, m_h24));
      wr(0, enc(ms, m_bin));
      wr(2, enc(mm, m_bin));
      wr(4, hour_byte(mh, m_bin, m_h24));
      wr(6, enc(mw, m_bin));
      wr(7, enc(md, m_bin));
   endtask

   task automatic model_step();
      ms++;
      if (ms == 60) begin
         ms = 0; mm++;
         if (mm == 60) begin
            mm = 0; mh++;
            if (mh == 24) begin
               mh = 0;
               mw = (mw == 7) ? 1 : mw + 1;
               md = (md == 31) ? 1 : md + 1;
            end
         end
      end
   endtask

   task automatic compare_time(input string tag);
      int v;
      rd(0, v); check({"R5 ", tag}, "seconds", v, enc(ms, m_bin));
      rd(2, v); check({"R5 ", tag}, "minutes", v, enc(mm, m_bin));
      rd(4, v);
      if (m_h24) check({"R7 ", tag}, "hours", v, hour_byte(mh, m_bin, m_h24));
      else       check({"R8 ", tag}, "hours", v, hour_byte(mh, m_bin, m_h24));
      rd(6, v); check({"R9 ", tag}, "day of week", v, enc(mw, m_bin));
      rd(7, v); check({"R9 ", tag}, "day of month", v, enc(md, m_bin));
   endtask

   // one full update window with timing checks, then the time compare
   task automatic run_second(input string tag);
      int s0, lead, tail, dones;
      bit changed, ended, done_at_fall;
      rd(0, s0);
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      check("R3", "uip after tick", int'(uip), 1);
      lead = 0; tail = 0; dones = 0; changed = 0; ended = 0; done_at_fall = 0;
      for (int k = 0; k < 400 && !ended; k++) begin
         ref_tick = (k % 2 == 0);
         @(negedge clk);
         if (ref_tick) begin
            if (!changed) lead++;
            else tail++;
         end
         if (!changed && int'(rd_data) != s0) changed = 1;
         if (upd_done) dones++;
         if (!uip) begin
            ended = 1;
            done_at_fall = upd_done;
         end
      end
      ref_tick = 1'b0;
      check({"R3 ", tag}, "ref ticks before change", lead, LEAD);
      check({"R4 ", tag}, "ref ticks after change", tail, UPD);
      check({"R4 ", tag}, "done pulses", dones, 1);
      check({"R4 ", tag}, "done at uip fall", int'(done_at_fall), 1);
      model_step();
      compare_time(tag);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      rd(0, v);  check("R1", "seconds", v, 8'h00);
      rd(2, v);  check("R1", "minutes", v, 8'h00);
      rd(4, v);  check("R1", "hours", v, 8'h00);
      rd(6, v);  check("R1", "day of week", v, 8'h01);
      rd(7, v);  check("R1", "day of month", v, 8'h01);
      rd(11, v); check("R1", "control", v, 8'h02);
      check("R1", "uip", int'(uip), 0);
      check("R1", "upd_done", int'(upd_done), 0);

      // R2 register map
      rd(13, v); check("R2", "validity", v, 8'h80);
      wr(13, 8'h00);
      rd(13, v); check("R2", "validity after write", v, 8'h80);
      wr(10, 8'hFF);
      rd(10, v); check("R2", "status after write", v, 8'h00);
      rd(1, v);  check("R2", "undefined offset", v, 8'h00);
      wr(11, 8'hFF);
      rd(11, v); check("R2", "control readback", v, 8'h86);
      wr(11, 8'h02);
      wr(0, 8'h37);
      rd(0, v);  check("R2", "seconds write", v, 8'h37);

      // R5 R6 seconds sweep across a minute boundary, packed decimal
      m_bin = 0; m_h24 = 1;
      ms = 0; mm = 4; mh = 9; mw = 3; md = 12;
      load_model();
      for (int i = 0; i < 62; i++) run_second("R6 sweep");

      // R6 R7 R8 R9 every hour, all format and mode combinations
      for (int f = 0; f < 4; f++) begin
         m_bin = f[0]; m_h24 = f[1];
         for (int h = 0; h < 24; h++) begin
            ms = 59; mm = 59; mh = h;
            mw = (h % 7) + 1;
            md = (h == 23) ? 31 : h + 1;
            load_model();
            run_second(m_h24 ? "R7 hour" : "R8 hour");
         end
      end

      // R10 hold blocks windows and time
      m_bin = 0; m_h24 = 1;
      ms = 20; mm = 10; mh = 5; mw = 2; md = 2;
      load_model();
      wr(11, ctrl_byte(1, 0, 1));
      begin
         int seen_uip, seen_done;
         seen_uip = 0; seen_done = 0;
         @(negedge clk); sec_tick = 1'b1;
         @(negedge clk); sec_tick = 1'b0;
         for (int k = 0; k < 200; k++) begin
            ref_tick = (k % 2 == 0);
            @(negedge clk);
            if (uip) seen_uip++;
            if (upd_done) seen_done++;
         end
         ref_tick = 1'b0;
         check("R10", "uip while held", seen_uip, 0);
         check("R10", "done while held", seen_done, 0);
         rd(0, v); check("R10", "seconds while held", v, enc(ms, 0));
      end

      // R10 hold set inside an open window aborts it
      wr(11, ctrl_byte(0, 0, 1));
      begin
         int seen_uip, seen_done;
         seen_uip = 0; seen_done = 0;
         @(negedge clk); sec_tick = 1'b1;
         @(negedge clk); sec_tick = 1'b0;
         for (int k = 0; k < 6; k++) begin
            ref_tick = (k % 2 == 0);
            @(negedge clk);
         end
         ref_tick = 1'b0;
         check("R10", "window open before hold", int'(uip), 1);
         wr(11, ctrl_byte(1, 0, 1));
         @(negedge clk);
         check("R10", "uip after hold write", int'(uip), 0);
         for (int k = 0; k < 200; k++) begin
            ref_tick = (k % 2 == 0);
            @(negedge clk);
            if (uip) seen_uip++;
            if (upd_done) seen_done++;
         end
         ref_tick = 1'b0;
         check("R10", "uip after abort", seen_uip, 0);
         check("R10", "done after abort", seen_done, 0);
         rd(0, v); check("R10", "seconds after abort", v, enc(ms, 0));
      end
      wr(11, ctrl_byte(0, 0, 1));
      run_second("R10 resume");

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule